// File: doc/BRIEF.md
# Accumulator Processor with Carry-Conditional Jump

This block is a small 8-bit multi-cycle processor. Its state is one accumulator, one carry flag, a 6-bit program counter, an instruction register and an operand register. Program and data share one 64-byte memory outside the block. The block reaches that memory through one address bus, a read-data bus, a write-data bus, an enable and a write enable. Memory reads are asynchronous: read data must be valid in the same cycle the address is driven. Writes take effect at the clock edge that ends a cycle in which both the enable and the write enable are high.

The instruction set has four instructions: a NOR into the accumulator, an add with carry-out, a store of the accumulator, and a jump taken only while the carry is clear. When the carry is set, the jump instruction clears the carry and falls through instead. A jump placed in a loop on itself therefore acts as an unconditional jump once the carry has been cleared.

A controller state machine sequences each instruction: fetch, decode, then operand read and execute, or store, or jump. It drives the datapath through a bundle of load, clear and select strobes.

Top module: `acc_core`

## Requirements
- R1: Each instruction is one byte. Bits [7:6] are the opcode (00 NOR, 01 ADD, 10 STORE, 11 JUMP-IF-CARRY-CLEAR) and bits [5:0] are a memory address or jump target.
- R2: NOR sets the accumulator to the bitwise NOR of the accumulator and the memory byte at the address. It leaves the carry unchanged.
- R3: ADD sets the accumulator to the 8-bit sum of the accumulator and the memory byte at the address. It sets the carry to the carry-out of that sum.
- R4: STORE writes the accumulator to the memory byte at the address. It does this in one cycle with both enable and write enable high, and write enable is never high without enable.
- R5: JUMP with the carry clear loads the program counter with the target.
- R6: JUMP with the carry set clears the carry and continues at the next instruction.
- R7: Reset clears the program counter, instruction register, operand register, accumulator and carry. While reset is held, the block drives address 0 with enable high and write enable low.
- R8: The program counter advances by one on every fetch and wraps from 63 to 0.
- R9: NOR and ADD read their operand into the operand register in a cycle of its own, before the execute cycle. NOR and ADD take 4 cycles; STORE and JUMP take 3 cycles.
- R10: With byte 7 = 0x7E and byte 8 = 0xFF, the program NOR 8, ADD 7, STORE 6, JUMP 4, JUMP 4 leaves 0x7E at byte 6 and ends looping at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| memAddr | output | 6 | Memory address: program counter or instruction target |
| memRdata | input | 8 | Byte read from memory at memAddr (asynchronous read) |
| memWdata | output | 8 | Accumulator value to be written |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Write enable, qualified by memEn |

## Verification
A sweep over 256 pairs of accumulator and operand values, including 0x00 and 0xFF, checks the sum, the carry-out and a following NOR. The carry-out is detected through the path the jump takes. If NOR disturbed the carry, or the add lost its carry-out, the jump would take the wrong path and the write to the marker byte would appear or vanish. A jump that failed to clear the carry leaves the final loop at the wrong address. A program counter that did not wrap never re-fetches address 0 after address 63. A controller that merged the operand read into execute stores at the wrong cycle in the reference program.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int DATA_W = 8;
  localparam int OPC_W  = 2;

  typedef enum logic [1:0] {
    OP_NOR = 2'b00,
    OP_ADD = 2'b01,
    OP_STA = 2'b10,
    OP_JCC = 2'b11
  } opcode_t;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_READ_OP, ST_EXEC, ST_STORE, ST_JUMP
  } state_t;

  typedef struct packed {
    logic ldIr;
    logic incPc;
    logic ldPc;
    logic ldOp;
    logic ldAcc;
    logic ldCarry;
    logic clrCarry;
    logic aluAdd;
    logic addrFromIr;
  } strobe_t;
endpackage

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W = acc_pkg::DATA_W,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           s,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output opcode_t           opcode,
  output logic              carry
);
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir, opReg, acc, aluRes;
  logic [DATA_W:0]   aluSum;

  assign aluSum   = {1'b0, acc} + {1'b0, opReg};
  assign aluRes   = s.aluAdd ? aluSum[DATA_W-1:0] : ~(acc | opReg);
  assign memAddr  = s.addrFromIr ? ir[ADDR_W-1:0] : pc;
  assign memWdata = acc;
  assign opcode   = opcode_t'(ir[DATA_W-1 -: OPC_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc    <= '0;
      ir    <= '0;
      opReg <= '0;
      acc   <= '0;
      carry <= 1'b0;
    end else begin
      if (s.ldIr) ir <= memRdata;
      if (s.ldPc) pc <= ir[ADDR_W-1:0];
      else if (s.incPc) pc <= pc + 1'b1;
      if (s.ldOp) opReg <= memRdata;
      if (s.ldAcc) acc <= aluRes;
      if (s.ldCarry) carry <= aluSum[DATA_W];
      else if (s.clrCarry) carry <= 1'b0;
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(s.incPc) && !$past(s.ldPc) |-> pc == $past(pc) + 1'b1); // R8
  AST_NOR_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    s.ldAcc && !s.aluAdd |=> $stable(carry)); // R2
  AST_JCC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    s.clrCarry |=> !carry); // R6
endmodule

// File: rtl/acc_control.sv
module acc_control
  import acc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  opcode_t opcode,
  input  logic    carry,
  output strobe_t s,
  output logic    memEn,
  output logic    memWe
);
  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FETCH;
    else state <= stateNext;
  end

  always_comb begin
    s = '0;
    memEn = 1'b0;
    memWe = 1'b0;
    stateNext = state;
    unique case (state)
      ST_FETCH: begin
        memEn = 1'b1;
        s.ldIr = 1'b1;
        s.incPc = 1'b1;
        stateNext = ST_DECODE;
      end
      ST_DECODE: begin
        unique case (opcode)
          OP_NOR, OP_ADD: stateNext = ST_READ_OP;
          OP_STA:         stateNext = ST_STORE;
          OP_JCC:         stateNext = ST_JUMP;
        endcase
      end
      ST_READ_OP: begin
        memEn = 1'b1;
        s.addrFromIr = 1'b1;
        s.ldOp = 1'b1;
        stateNext = ST_EXEC;
      end
      ST_EXEC: begin
        s.ldAcc = 1'b1;
        s.aluAdd = (opcode == OP_ADD);
        s.ldCarry = (opcode == OP_ADD);
        stateNext = ST_FETCH;
      end
      ST_STORE: begin
        memEn = 1'b1;
        memWe = 1'b1;
        s.addrFromIr = 1'b1;
        stateNext = ST_FETCH;
      end
      ST_JUMP: begin
        s.ldPc = !carry;
        s.clrCarry = carry;
        stateNext = ST_FETCH;
      end
      default: stateNext = ST_FETCH;
    endcase
  end

  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memEn); // R4
  AST_EXEC_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    s.ldAcc |-> $past(s.ldOp)); // R9
  AST_JUMP_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    s.ldPc |-> !carry); // R5
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = acc_pkg::DATA_W,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memWdata,
  output logic              memEn,
  output logic              memWe
);
  strobe_t strobes;
  opcode_t opcode;
  logic    carry;

  acc_control u_ctrl (
    .clk(clk), .rstN(rstN), .opcode(opcode), .carry(carry),
    .s(strobes), .memEn(memEn), .memWe(memWe)
  );

  acc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .s(strobes), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .opcode(opcode), .carry(carry)
  );
endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] memAddr;
  logic [7:0] memRdata, memWdata;
  logic memEn, memWe;

  logic [7:0] mem [64];
  int wrCnt [64];
  int rdCnt [64];
  int lastLow;
  int firstWr;
  int cyc;
  int total = 0;
  int bad = 0;
  int wdog = 0;

  always #2 clk = ~clk;

  acc_core dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRdata(memRdata),
    .memWdata(memWdata), .memEn(memEn), .memWe(memWe)
  );

  assign memRdata = mem[memAddr];

  always @(posedge clk) begin
    if (rstN) begin
      if (memEn && memWe) begin
        mem[memAddr] <= memWdata;
        wrCnt[memAddr] = wrCnt[memAddr] + 1;
        if (firstWr < 0) firstWr = cyc;
      end else if (memEn) begin
        rdCnt[memAddr] = rdCnt[memAddr] + 1;
        if (memAddr < 6'd40) lastLow = int'(memAddr);
      end
      cyc = cyc + 1;
    end
  end

  always @(posedge clk) begin
    wdog = wdog + 1;
    if (wdog > 190000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=%0d", wdog, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] enc(input logic [1:0] op, input int a);
    return {op, 6'(a)};
  endfunction

  function automatic logic [7:0] pat(input int k);
    if (k == 0) return 8'h00;
    if (k == 15) return 8'hFF;
    return 8'((k * 37 + 3) & 255);
  endfunction

  task automatic clearAll();
    rstN = 1'b0;
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'h00;
      wrCnt[i] = 0;
      rdCnt[i] = 0;
    end
    lastLow = -1;
    firstWr = -1;
    cyc = 0;
  endtask

  task automatic release_(input int n);
    @(negedge clk);
    @(negedge clk);
    // R7: during reset the block fetches address 0 and does not write
    chk(memAddr == 6'd0 && memEn && !memWe, "R7 reset bus", {memAddr, memEn, memWe}, 8'h02);
    rstN = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R10 reference program, R9 timing, R1 encoding
    clearAll();
    mem[0] = enc(2'b00, 8);
    mem[1] = enc(2'b01, 7);
    mem[2] = enc(2'b10, 6);
    mem[3] = enc(2'b11, 4);
    mem[4] = enc(2'b11, 4);
    mem[7] = 8'h7E;
    mem[8] = 8'hFF;
    release_(60);
    chk(mem[6] == 8'h7E, "R10 stored byte", mem[6], 8'h7E);
    chk(wrCnt[6] == 1, "R10 single store", wrCnt[6], 1);
    chk(lastLow == 4, "R10 loop address", lastLow, 4);
    chk(firstWr == 10, "R9 store cycle", firstWr, 10);

    // R8: wrap 63 -> 0
    clearAll();
    mem[0] = enc(2'b11, 62);
    mem[62] = enc(2'b00, 40);
    mem[63] = enc(2'b10, 42);
    mem[40] = 8'hC3;
    release_(40);
    chk(wrCnt[42] >= 2, "R8 wrap store count", wrCnt[42], 2);
    chk(rdCnt[0] >= 2, "R8 refetch of 0", rdCnt[0], 2);
    chk(rdCnt[62] >= 2, "R5 jump target fetched", rdCnt[62], 2);

    // sweep: R2 R3 R4 R5 R6
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [7:0] a, b, c, sum, norv;
        logic [8:0] full;
        a = pat(i);
        b = pat(j);
        c = a ^ b ^ 8'h33;
        full = {1'b0, a} + {1'b0, b};
        sum = full[7:0];
        norv = ~(sum | c);
        clearAll();
        mem[0] = enc(2'b00, 40);
        mem[1] = enc(2'b01, 41);
        mem[2] = enc(2'b10, 42);
        mem[3] = enc(2'b00, 44);
        mem[4] = enc(2'b10, 45);
        mem[5] = enc(2'b11, 8);
        mem[6] = enc(2'b10, 46);
        mem[7] = enc(2'b11, 7);
        mem[8] = enc(2'b11, 8);
        mem[40] = ~a;
        mem[41] = b;
        mem[44] = c;
        release_(50);
        chk(mem[42] == sum, "R3 sum", mem[42], sum);
        chk(mem[45] == norv, "R2 nor", mem[45], norv);
        chk((wrCnt[46] == 1) == full[8], "R2/R3 carry path", wrCnt[46], full[8]);
        chk(lastLow == (full[8] ? 7 : 8), "R5/R6 final loop", lastLow, full[8] ? 7 : 8);
        chk(wrCnt[40] == 0 && wrCnt[41] == 0, "R4 only addressed byte written",
            wrCnt[40] + wrCnt[41], 0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule